// File: doc/BRIEF.md
# Low supply wake supervisor

This block decides whether the processor is allowed to run while the chip draws its power only from a backup battery. It watches a main-power-present input, a core-supply-good comparator, a 3-bit supply status code, a firmware sleep request and a wake-attempt strobe. All of these arrive on the slow 32768 Hz clock. From them it drives the processor hold line (`wake`, where high lets the processor run), a brownout-mode indication and a sticky flag. The flag tells firmware that it is recovering from a bad battery episode.

When the status code reports a collapsing core supply and main power is absent, a fixed countdown starts. If firmware asks for sleep before the countdown ends, the block goes to sleep. If firmware does not, the processor is forced into hold at the end of the countdown and the block waits in brownout configuration until the supply comes back. The same waiting state is entered when a wake attempt from sleep finds neither main power nor a good core supply.

The level inputs pass through a two-stage synchronizer before use. The code and the strobe are taken as synchronous to the slow clock.

Top module: `lowsup_wake_sup`

## Requirements
- R1: `mains_ok`, `vcore_ok` and `sleep_req` act only through a two-stage synchronizer, so a change on one of them shows on the outputs three clock edges after it is applied and not earlier.
- R2: A one-cycle `wake_try` pulse while asleep, with main power absent and the core supply not good, keeps `wake` low and raises `brown_mode` on the next edge. The block then stays in that waiting state.
- R3: While waiting, a good core supply or the return of main power drives `wake` high and `brown_mode` low.
- R4: With main power absent and no sleep request, a `sup_code` of 3'b101 sampled on an edge starts a countdown. `wake` falls and `brown_mode` rises exactly four edges later.
- R5: A synchronized sleep request while running, or during the countdown, drops `wake` without raising `brown_mode`. A request that arrives before the countdown expires overrides the forced hold.
- R6: When `wake` rises on leaving the waiting state, `bad_sup_flag` is set on the same edge.
- R7: `bad_sup_flag` stays set until the next falling edge of `wake` and clears on that edge. A wake from sleep that finds a good supply does not set it.
- R8: While main power is present, `sup_code` has no effect: `wake` stays high for any code value.
- R9: Synchronous active-high `rst` sets `wake` high and clears `brown_mode`, `bad_sup_flag` and the countdown, from any state.
- R10: A `wake_try` pulse while asleep, with main power present or the core supply good, raises `wake` on the next edge with `brown_mode` low.
- R11: The return of main power during the countdown cancels it, and `wake` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz slow clock |
| rst | input | 1 | Synchronous active-high chip reset |
| mains_ok | input | 1 | Main system power present (asynchronous) |
| vcore_ok | input | 1 | Core supply above threshold (asynchronous) |
| sup_code | input | CODE_W | Supply status code; LOW_CODE (3'b101) means core supply low |
| sleep_req | input | 1 | Firmware sleep request (asynchronous level) |
| wake_try | input | 1 | One-cycle wake attempt strobe while asleep |
| wake | output | 1 | High lets the processor run; low holds it |
| brown_mode | output | 1 | High while waiting in brownout configuration |
| bad_sup_flag | output | 1 | Sticky recovery-from-bad-supply flag |

## Verification
Each result is due at a fixed number of edges. A level change on a synchronized input reaches the outputs on the third edge after it is applied. A `wake_try` pulse acts on the first edge. A low-supply code acts on the first edge and has its forced hold on the fifth. The bench drives inputs and samples outputs on falling clock edges. It counts falling edges from the stimulus and checks each output one edge before it is due, where it must still hold the old value, and again on the edge it is due. For the sleep override, the request is placed so that its synchronized copy lands before the countdown expires. The bench then keeps observing past the expiry point to confirm that no brownout follows.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_COUNT = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAIT  = 2'd3
    } lsw_state_e;

    typedef struct packed {
        lsw_state_e state;
        logic       wake;
        logic       brown;
        logic       flag;
    } lsw_regs_t;

    localparam lsw_regs_t LSW_REGS_RST = '{state: ST_RUN, wake: 1'b1, brown: 1'b0, flag: 1'b0};

endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lsw_timer.sv
module lsw_timer #(
    parameter int CNT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic expired
);

    localparam int CW = $clog2(CNT_LEN + 1);
    localparam logic [CW-1:0] CNT_END = CW'(CNT_LEN);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CNT_END);

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(1);
        end else if (!active) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lsw_fsm.sv
module lsw_fsm
    import lsw_pkg::*;
#(
    parameter int               CODE_W   = 3,
    parameter logic [CODE_W-1:0] LOW_CODE = 3'b101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mains_s,
    input  logic              vcore_s,
    input  logic              sleep_s,
    input  logic [CODE_W-1:0] sup_code,
    input  logic              wake_try,
    input  logic              expired,
    output logic              tmr_start,
    output logic              tmr_active,
    output logic              wake,
    output logic              brown,
    output logic              flag
);

    lsw_regs_t  regs_d;
    lsw_regs_t  regs_q;
    lsw_state_e nxt;
    logic       code_low;
    logic       supply_back;

    assign code_low    = (sup_code == LOW_CODE);
    assign supply_back = mains_s || vcore_s;
    assign tmr_active  = (regs_q.state == ST_COUNT);

    always_comb begin
        regs_d    = regs_q;
        nxt       = regs_q.state;
        tmr_start = 1'b0;
        unique case (regs_q.state)
            ST_RUN: begin
                if (sleep_s) begin
                    nxt = ST_SLEEP;
                end else if (!mains_s && code_low) begin
                    nxt       = ST_COUNT;
                    tmr_start = 1'b1;
                end
            end
            ST_COUNT: begin
                if (mains_s) begin
                    nxt = ST_RUN;
                end else if (sleep_s) begin
                    nxt = ST_SLEEP;
                end else if (expired) begin
                    nxt = ST_WAIT;
                end
            end
            ST_SLEEP: begin
                if (wake_try) begin
                    nxt = supply_back ? ST_RUN : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (supply_back) begin
                    nxt = ST_RUN;
                end
            end
            default: nxt = ST_RUN;
        endcase

        regs_d.state = nxt;
        regs_d.wake  = (nxt == ST_RUN) || (nxt == ST_COUNT);
        regs_d.brown = (nxt == ST_WAIT);

        if (regs_q.wake && !regs_d.wake) begin
            regs_d.flag = 1'b0;
        end else if ((regs_q.state == ST_WAIT) && (nxt == ST_RUN)) begin
            regs_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= LSW_REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign wake  = regs_q.wake;
    assign brown = regs_q.brown;
    assign flag  = regs_q.flag;

endmodule

// File: rtl/lowsup_wake_sup.sv
module lowsup_wake_sup #(
    parameter int               SYNC_STAGES = 2,
    parameter int               CNT_LEN     = 4,
    parameter int               CODE_W      = 3,
    parameter logic [CODE_W-1:0] LOW_CODE    = 3'b101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mains_ok,
    input  logic              vcore_ok,
    input  logic [CODE_W-1:0] sup_code,
    input  logic              sleep_req,
    input  logic              wake_try,
    output logic              wake,
    output logic              brown_mode,
    output logic              bad_sup_flag
);

    localparam int NSYNC = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b110;

    logic [NSYNC-1:0] sync_in;
    logic [NSYNC-1:0] sync_out;
    logic             mains_s;
    logic             vcore_s;
    logic             sleep_s;
    logic             tmr_start;
    logic             tmr_active;
    logic             tmr_expired;

    assign sync_in = {mains_ok, vcore_ok, sleep_req};
    assign mains_s = sync_out[2];
    assign vcore_s = sync_out[1];
    assign sleep_s = sync_out[0];

    lsw_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (sync_in),
        .q  (sync_out)
    );

    lsw_timer #(
        .CNT_LEN(CNT_LEN)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (tmr_start),
        .active (tmr_active),
        .expired(tmr_expired)
    );

    lsw_fsm #(
        .CODE_W  (CODE_W),
        .LOW_CODE(LOW_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mains_s   (mains_s),
        .vcore_s   (vcore_s),
        .sleep_s   (sleep_s),
        .sup_code  (sup_code),
        .wake_try  (wake_try),
        .expired   (tmr_expired),
        .tmr_start (tmr_start),
        .tmr_active(tmr_active),
        .wake      (wake),
        .brown     (brown_mode),
        .flag      (bad_sup_flag)
    );

endmodule

// File: rtl/lsw_chk.sv
module lsw_chk (
    input logic clk,
    input logic rst,
    input logic wake,
    input logic brown_mode,
    input logic bad_sup_flag,
    input logic wake_try,
    input logic mains_s,
    input logic sleep_s,
    input logic expired
);

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (wake && !brown_mode && !bad_sup_flag)); // R9

    AST_BROWN_HOLDS: assert property (@(posedge clk) disable iff (rst) brown_mode |-> !wake); // R2

    AST_BROWN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(brown_mode) |-> ($past(expired) || $past(wake_try))); // R4

    AST_SLEEP_NO_BROWN: assert property (@(posedge clk) disable iff (rst)
        (wake && sleep_s) |=> !brown_mode); // R5

    AST_MAINS_KEEPS_WAKE: assert property (@(posedge clk) disable iff (rst)
        (wake && mains_s && !sleep_s) |=> wake); // R8

    AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(bad_sup_flag) |-> $rose(wake)); // R6

    AST_FLAG_CLR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(wake) |-> !bad_sup_flag); // R7

endmodule

bind lowsup_wake_sup lsw_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wake        (wake),
    .brown_mode  (brown_mode),
    .bad_sup_flag(bad_sup_flag),
    .wake_try    (wake_try),
    .mains_s     (mains_s),
    .sleep_s     (sleep_s),
    .expired     (tmr_expired)
);

// File: tb/lowsup_wake_sup_tb_top.sv
module lowsup_wake_sup_tb_top;

    localparam int WD_LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mains_ok = 1'b1;
    logic       vcore_ok = 1'b1;
    logic [2:0] sup_code = 3'b000;
    logic       sleep_req = 1'b0;
    logic       wake_try = 1'b0;
    logic       wake;
    logic       brown_mode;
    logic       bad_sup_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lowsup_wake_sup dut_i (
        .clk         (clk),
        .rst         (rst),
        .mains_ok    (mains_ok),
        .vcore_ok    (vcore_ok),
        .sup_code    (sup_code),
        .sleep_req   (sleep_req),
        .wake_try    (wake_try),
        .wake        (wake),
        .brown_mode  (brown_mode),
        .bad_sup_flag(bad_sup_flag)
    );

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic pulse_try();
        wake_try = 1'b1;
        nwait(1);
        wake_try = 1'b0;
    endtask

    task automatic t_reset_state();
        nwait(3);
        chk("R9", "wake in reset", wake, 1'b1);
        chk("R9", "brown in reset", brown_mode, 1'b0);
        chk("R9", "flag in reset", bad_sup_flag, 1'b0);
        rst = 1'b0;
        nwait(3);
    endtask

    task automatic t_code_ignored();
        sup_code = 3'b101;
        nwait(8);
        chk("R8", "wake with mains and low code", wake, 1'b1);
        chk("R8", "brown with mains and low code", brown_mode, 1'b0);
        sup_code = 3'b000;
        nwait(1);
    endtask

    task automatic t_countdown();
        mains_ok = 1'b0;
        vcore_ok = 1'b0;
        nwait(3);
        sup_code = 3'b101;
        nwait(4);
        chk("R4", "wake one edge before expiry", wake, 1'b1);
        nwait(1);
        chk("R4", "wake at expiry", wake, 1'b0);
        chk("R4", "brown at expiry", brown_mode, 1'b1);
        sup_code = 3'b000;
        nwait(5);
        chk("R2", "still waiting", brown_mode, 1'b1);
    endtask

    task automatic t_recover();
        vcore_ok = 1'b1;
        nwait(2);
        chk("R1", "wake before sync latency", wake, 1'b0);
        nwait(1);
        chk("R3", "wake after supply good", wake, 1'b1);
        chk("R3", "brown after supply good", brown_mode, 1'b0);
        chk("R6", "flag on recovery", bad_sup_flag, 1'b1);
        nwait(6);
        chk("R7", "flag held", bad_sup_flag, 1'b1);
    endtask

    task automatic t_sleep_from_run();
        sleep_req = 1'b1;
        nwait(2);
        chk("R1", "wake before sleep sync", wake, 1'b1);
        nwait(1);
        chk("R5", "wake after sleep", wake, 1'b0);
        chk("R5", "no brown on sleep", brown_mode, 1'b0);
        chk("R7", "flag cleared on wake fall", bad_sup_flag, 1'b0);
        sleep_req = 1'b0;
        nwait(3);
    endtask

    task automatic t_good_wake();
        pulse_try();
        chk("R10", "wake from sleep good supply", wake, 1'b1);
        chk("R10", "no brown good supply", brown_mode, 1'b0);
        chk("R7", "no flag on good wake", bad_sup_flag, 1'b0);
    endtask

    task automatic t_preempt();
        sup_code = 3'b101;
        nwait(1);
        sleep_req = 1'b1;
        nwait(3);
        chk("R5", "wake after preempting sleep", wake, 1'b0);
        chk("R5", "brown after preempting sleep", brown_mode, 1'b0);
        nwait(3);
        chk("R5", "no forced wait after expiry point", brown_mode, 1'b0);
        sleep_req = 1'b0;
        sup_code  = 3'b000;
        nwait(3);
    endtask

    task automatic t_bad_wake();
        vcore_ok = 1'b0;
        nwait(3);
        pulse_try();
        chk("R2", "wake on bad wake attempt", wake, 1'b0);
        chk("R2", "brown on bad wake attempt", brown_mode, 1'b1);
        mains_ok = 1'b1;
        nwait(2);
        chk("R1", "brown before mains sync", brown_mode, 1'b1);
        nwait(1);
        chk("R3", "wake on mains return", wake, 1'b1);
        chk("R3", "brown on mains return", brown_mode, 1'b0);
        chk("R6", "flag on mains recovery", bad_sup_flag, 1'b1);
    endtask

    task automatic t_cancel();
        mains_ok = 1'b0;
        nwait(3);
        sup_code = 3'b101;
        mains_ok = 1'b1;
        nwait(6);
        chk("R11", "wake after cancelled countdown", wake, 1'b1);
        chk("R11", "no brown after cancel", brown_mode, 1'b0);
        chk("R7", "flag kept without wake fall", bad_sup_flag, 1'b1);
        sup_code = 3'b000;
        nwait(1);
    endtask

    task automatic t_reset_mid();
        rst = 1'b1;
        nwait(1);
        chk("R9", "flag cleared by reset", bad_sup_flag, 1'b0);
        chk("R9", "wake in reset from run", wake, 1'b1);
        rst = 1'b0;
        mains_ok = 1'b0;
        vcore_ok = 1'b0;
        nwait(3);
        sup_code = 3'b101;
        nwait(5);
        chk("R4", "brown before reset", brown_mode, 1'b1);
        sup_code = 3'b000;
        rst = 1'b1;
        nwait(1);
        chk("R9", "wake after reset from wait", wake, 1'b1);
        chk("R9", "brown after reset from wait", brown_mode, 1'b0);
        rst = 1'b0;
        nwait(2);
    endtask

    initial begin
        t_reset_state();
        t_code_ignored();
        t_countdown();
        t_recover();
        t_sleep_from_run();
        t_good_wake();
        t_preempt();
        t_bad_wake();
        t_cancel();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule